// File: doc/BRIEF.md
# Delayed-Edge Square Wave Regenerator

This block rebuilds a reference square wave on a new output, with both of its edges pushed later by the same number of system-clock ticks. An upstream measurement stage supplies a phase difference in ticks. The block also receives the reference level, already synchronized to the system clock, together with one-cycle strobes that mark its rising and falling edges. On each reference rise the block takes the phase difference and subtracts a fixed correction that covers the latency of the input synchronizers. It clamps the result into a legal range and loads it into a down-counter. It also keeps the result for reuse at the following fall.

While the counter runs, the output holds the opposite of the newest reference level. When the counter reaches zero, the output takes that level. Both edges therefore move by the same amount and the duty cycle is kept. The delay used in a period is whatever was presented at that period's rise, so the output tracks a measurement made one period earlier.

Top module: `edr_regen`

## Requirements
- R1: While the synchronous active-low reset is asserted, the output wave is low and the delay counter is zero.
- R2: After reset, fall strobes and reference level changes have no effect, and the output stays low, until the first rise strobe is seen.
- R3: A rise strobe sampled at clock edge k with phase value P (where P-LAT_COMP lies in 0..MAX_DELAY) loads D = P-LAT_COMP. The output is low after edges k..k+D-1 and high from edge k+D onward. With D = 0 the output is high right after edge k.
- R4: When P is below LAT_COMP, the loaded delay is zero, and the output turns high right after the edge that samples the rise strobe.
- R5: When P-LAT_COMP exceeds MAX_DELAY, the loaded delay is MAX_DELAY. The counter never holds a value above MAX_DELAY.
- R6: A fall strobe sampled at edge k, with the reference level low, reloads the delay stored at the last rise. The output is high after edges k..k+D-1 and low from edge k+D onward.
- R7: While the counter is nonzero and no strobe arrives, it drops by exactly one per clock, and the output shows the inverse of the latched reference level.
- R8: When rise and fall strobes arrive in the same cycle, the rise wins and a new delay is loaded from the phase input.
- R9: The phase input is sampled only on a rise strobe. Values it takes at other times, including during a fall, do not change the stored delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_lvl_i | input | 1 | Synchronized reference level |
| ref_rise_i | input | 1 | One-cycle strobe on a reference rising edge |
| ref_fall_i | input | 1 | One-cycle strobe on a reference falling edge |
| phase_diff_i | input | CNT_W | Measured phase difference in ticks, sampled on a rise strobe |
| wave_out_o | output | 1 | Regenerated, delayed square wave |

## Verification
A strobe sampled at edge k sets the counter and the latched level at that edge. The output is formed combinationally from those registers, so it shows the inverse level just after edge k and the new level just after edge k+D. The bench drives inputs just after a falling clock edge and compares the output at the next falling edge. A reference model counts the rising edges since the last accepted strobe and predicts the level that is due in each cycle. Every cycle of every period is compared, so an edge that is one tick early or late is caught as well as a wrong level.

// File: rtl/edr_pkg.sv
// Shared types for the delayed-edge regenerator.
// Assumes: one event per cycle; a rise outranks a fall.
package edr_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } edr_event_t;

    // Reduce the two strobes to a single event; a fall counts only once armed.
    function automatic edr_event_t edr_classify(input logic rise, input logic fall,
                                                input logic armed);
        if (rise)
            return EV_RISE;
        else if (fall && armed)
            return EV_FALL;
        else
            return EV_NONE;
    endfunction

endpackage

// File: rtl/edr_delay_calc.sv
// Turns a measured phase difference into a loadable delay.
// Subtracts the synchronizer latency, floors the result at zero and caps it
// at MAX_DELAY so a count always ends before the next reference edge.
// Assumes: MAX_DELAY fits in CNT_W bits and is below half a reference period.
module edr_delay_calc #(
    parameter int CNT_W     = 14,
    parameter int LAT_COMP  = 4,
    parameter int MAX_DELAY = 4999
) (
    input  logic [CNT_W-1:0] phase_i,
    output logic [CNT_W-1:0] delay_o
);
    localparam logic [CNT_W-1:0] LatV = CNT_W'(LAT_COMP);
    localparam logic [CNT_W-1:0] MaxV = CNT_W'(MAX_DELAY);

    logic [CNT_W-1:0] diff;

    // Subtract the latency, floor at zero, cap at the maximum delay.
    always_comb begin
        diff = phase_i - LatV;
        if (phase_i < LatV)
            delay_o = '0;
        else if (diff > MaxV)
            delay_o = MaxV;
        else
            delay_o = diff;
    end

endmodule

// File: rtl/edr_counter.sv
// Down-counter and stored delay.
// A rise loads a fresh delay into the counter and the store, a fall reloads
// the counter from the store, and otherwise a nonzero count drops by one.
// Assumes: load_i never exceeds MAX_DELAY.
module edr_counter
    import edr_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int MAX_DELAY = 4999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  edr_event_t       ev_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] MaxV = CNT_W'(MAX_DELAY);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] held_q;

    // Load, reload or count down the delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            held_q <= '0;
        end else begin
            case (ev_i)
                EV_RISE: begin
                    cnt_q  <= load_i;
                    held_q <= load_i;
                end
                EV_FALL: cnt_q <= held_q;
                default: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            endcase
        end
    end

    assign busy_o = (cnt_q != '0);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0);                                          // R1
    AST_RISE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i == EV_RISE |=> cnt_q == $past(load_i));                      // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MaxV);                                                   // R5
    AST_FALL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i == EV_FALL |=> cnt_q == $past(held_q));                      // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_NONE && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R7
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i != EV_RISE |=> $stable(held_q));                             // R9

endmodule

// File: rtl/edr_level.sv
// Latched reference level, armed flag and output selection.
// The output is the latched level, inverted while the counter is busy.
// Assumes: the counter is idle whenever the block is not armed.
module edr_level
    import edr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  edr_event_t ev_i,
    input  logic       ref_lvl_i,
    input  logic       busy_i,
    output logic       armed_o,
    output logic       wave_o
);
    logic lvl_q;

    // Capture the reference level on every accepted edge; arm on the first rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            armed_o <= 1'b0;
        end else begin
            case (ev_i)
                EV_RISE: begin
                    lvl_q   <= ref_lvl_i;
                    armed_o <= 1'b1;
                end
                EV_FALL: lvl_q <= ref_lvl_i;
                default: ;
            endcase
        end
    end

    // Hold the inverse level while a delay is still running.
    always_comb wave_o = busy_i ? ~lvl_q : lvl_q;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |-> !wave_o);                                            // R2
    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i == EV_NONE |=> $stable(lvl_q));                              // R7

endmodule

// File: rtl/edr_regen.sv
// Delayed-edge square wave regenerator, top level.
// Classifies the strobes, derives the delay and drives the regenerated wave.
// Assumes: the inputs are synchronous to clk and each strobe lasts one cycle.
module edr_regen
    import edr_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int LAT_COMP  = 4,
    parameter int MAX_DELAY = 4999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_lvl_i,
    input  logic             ref_rise_i,
    input  logic             ref_fall_i,
    input  logic [CNT_W-1:0] phase_diff_i,
    output logic             wave_out_o
);
    edr_event_t       ev;
    logic [CNT_W-1:0] delay;
    logic             busy;
    logic             armed;

    // One event per cycle; the rise takes priority.
    always_comb ev = edr_classify(ref_rise_i, ref_fall_i, armed);

    edr_delay_calc #(
        .CNT_W    (CNT_W),
        .LAT_COMP (LAT_COMP),
        .MAX_DELAY(MAX_DELAY)
    ) u_calc (
        .phase_i(phase_diff_i),
        .delay_o(delay)
    );

    edr_counter #(
        .CNT_W    (CNT_W),
        .MAX_DELAY(MAX_DELAY)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_i  (ev),
        .load_i(delay),
        .busy_o(busy)
    );

    edr_level u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .ref_lvl_i(ref_lvl_i),
        .busy_i   (busy),
        .armed_o  (armed),
        .wave_o   (wave_out_o)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !wave_out_o);                                          // R1
    AST_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise_i && ref_fall_i) |=> armed);                            // R8

endmodule

// File: tb/sim_edr_regen.sv
`timescale 1ns/1ps
module sim_edr_regen;
    localparam int CW   = 8;
    localparam int LAT  = 4;
    localparam int MAXD = 59;
    localparam int HALF = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lvl = 1'b0, rise = 1'b0, fall = 1'b0;
    logic [CW-1:0] pd = '0;
    logic wave;

    int n_cmp = 0, n_bad = 0;
    int m_armed = 0, m_lvl = 0, m_dly = 0, m_held = 0, m_age = 0;

    always #4 clk = ~clk;

    edr_regen #(.CNT_W(CW), .LAT_COMP(LAT), .MAX_DELAY(MAXD)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_lvl_i(lvl), .ref_rise_i(rise),
        .ref_fall_i(fall), .phase_diff_i(pd), .wave_out_o(wave));

    function automatic int exp_delay(input int p);
        int d;
        d = p - LAT;
        if (d < 0) d = 0;
        if (d > MAXD) d = MAXD;
        return d;
    endfunction

    function automatic logic exp_wave();
        if (m_age < m_dly) return logic'(m_lvl == 0);
        return logic'(m_lvl != 0);
    endfunction

    task automatic step(input logic r, input logic f, input logic l,
                        input int p, input string tag);
        rise = r; fall = f; lvl = l; pd = CW'(p);
        @(posedge clk); #1;
        if (!rst_n) begin
            m_armed = 0; m_lvl = 0; m_dly = 0; m_held = 0; m_age = 0;
        end else if (r) begin
            m_armed = 1; m_lvl = int'(l); m_dly = exp_delay(p); m_held = m_dly; m_age = 0;
        end else if (f && m_armed != 0) begin
            m_lvl = int'(l); m_dly = m_held; m_age = 0;
        end else if (m_age < 100000) begin
            m_age++;
        end
        @(negedge clk);
        n_cmp++;
        if (wave !== exp_wave()) begin
            n_bad++;
            $display("FAIL %s: wave actual=%b expected=%b at %0t", tag, wave, exp_wave(), $time);
        end
    endtask

    // One reference period: a rise carrying phase p, then a fall half a period later.
    task automatic period(input int p, input string tag);
        step(1'b1, 1'b0, 1'b1, p, tag);
        for (int i = 0; i < HALF - 1; i++) step(1'b0, 1'b0, 1'b1, int'($urandom_range(255)), {tag, " R7 R9"});
        step(1'b0, 1'b1, 1'b0, int'($urandom_range(255)), {tag, " R6 R9"});
        for (int i = 0; i < HALF - 1; i++) step(1'b0, 1'b0, 1'b0, int'($urandom_range(255)), {tag, " R6 R7"});
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 20, "R1 reset");
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, 30, "R2 unarmed");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1, 30, "R2 unarmed");
        period(10, "R3 nominal");
        period(0, "R4 clamp zero");
        period(3, "R4 below latency");
        period(4, "R3 zero delay");
        period(5, "R3 one tick");
        period(63, "R5 at maximum");
        period(255, "R5 capped");
        // Rise and fall strobes together: the rise wins.
        step(1'b1, 1'b1, 1'b1, 24, "R8 both strobes");
        for (int i = 0; i < HALF - 1; i++) step(1'b0, 1'b0, 1'b1, 0, "R8 both strobes");
        step(1'b0, 1'b1, 1'b0, 0, "R8 then fall");
        for (int i = 0; i < HALF - 1; i++) step(1'b0, 1'b0, 1'b0, 0, "R8 then fall");
        for (int n = 0; n < 150; n++) period(int'($urandom_range(255)), "R3 random");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule